// File: doc/BRIEF.md
# Multi-Pattern Serial Test Word Generator

This block feeds the transmit side of a serial transceiver with test data. Each clock it produces one parallel word. The serialiser sends bit 0 of that word first. A runtime select code picks one of six patterns: four pseudo-random binary sequences of different lengths, a bit-rate square wave and a slower square wave with a ten-bit period.

Every lane gets its own instance, so each lane has its own select. An invert control complements the whole word, which corrects a swapped differential pair without touching the board. The word width is fixed at build time to either 32 or 40 bits. The generator advances exactly that many bit-steps per clock, so the serial stream has no gaps or repeats at word boundaries.

When the select code changes, or on reset, the pseudo-random registers reload an all-ones seed and the square-wave phase returns to zero. The generator therefore never sits in the all-zero lock-up state, and a new pattern always starts from a known point.

Top module: `pattern_tx_gen`

## Requirements
- R1: While `rst_i` is high, `data_o` is all zeros and `valid_o` is 0 after the next rising clock edge.
- R2: Select code 0 gives the 7-stage sequence. Each bit-step computes f = s[6] xor s[5], shifts the 7-bit state left with f entering bit 0, and emits f. Word bit i is the i-th step of that clock, so bit 0 is the earliest. The seed is all ones. For either width, the word repeats every 127 words.
- R3: Codes 1, 2 and 3 use the same step rule. Code 1 has 15 stages with taps s[14], s[13]. Code 2 has 23 stages with taps s[22], s[17]. Code 3 has 31 stages with taps s[30], s[27]. All seeds are all ones, and the state never becomes all zeros.
- R4: Code 4 gives a square wave at half the bit rate: word bit i is 1 for even i and 0 for odd i.
- R5: Code 5 gives five ones followed by five zeros, continuing across word boundaries. Bit p of the stream, counted from the last reload, is 1 when p mod 10 < 5.
- R6: Codes 6 and 7 give an all-zero word, before any inversion.
- R7: When `invert_i` is high, every bit of the word registered at that edge is complemented.
- R8: `valid_o` equals `en_i` as sampled at the previous edge. While `en_i` is low, `data_o` holds and the pattern state does not advance.
- R9: A change in `pat_sel_i` reloads the seed and zeroes the phase at that edge, even while `en_i` is low.
- R10: A synchronous reset reloads the seed and phase, even when the select code does not change across the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Produce a word and advance the pattern this cycle |
| pat_sel_i | input | 3 | Pattern code (0-3 pseudo-random, 4 fast square, 5 slow square, 6-7 zero) |
| invert_i | input | 1 | Complement the output word |
| data_o | output | WIDTH | Registered parallel word, bit 0 sent first |
| valid_o | output | 1 | High when data_o holds a word produced in the previous cycle |

## Verification
The hardest cases to reach are reloads that nothing visible triggers: a select code that changes and changes back while enable is low, and a reset that leaves the select code unchanged. Neither shows up at the output until the next enabled word. The stimulus moves the select away and back with enable low, and resets in the middle of a run with the same code held. It then compares the words that follow against a bit-serial reference restarted from the seed. The 127-word repeat of the shortest sequence is also checked directly against the first captured word.

// File: rtl/pattern_pkg.sv
package pattern_pkg;

    localparam int NUM_LFSR = 4;
    localparam int LFSR_MAX = 31;
    localparam int NUM_SQ   = 2;
    localparam int PHASE_W  = 4;

    localparam logic [2:0] SEL_PRBS7  = 3'd0;
    localparam logic [2:0] SEL_PRBS15 = 3'd1;
    localparam logic [2:0] SEL_PRBS23 = 3'd2;
    localparam logic [2:0] SEL_PRBS31 = 3'd3;
    localparam logic [2:0] SEL_CLK2   = 3'd4;
    localparam logic [2:0] SEL_CLK10  = 3'd5;

    typedef logic [LFSR_MAX-1:0] lfsr_t;

    function automatic int lfsr_len(input int idx);
        case (idx)
            0:       return 7;
            1:       return 15;
            2:       return 23;
            default: return 31;
        endcase
    endfunction

    function automatic int lfsr_tap(input int idx);
        case (idx)
            0:       return 6;
            1:       return 14;
            2:       return 18;
            default: return 28;
        endcase
    endfunction

    function automatic int sq_half(input int idx);
        return (idx == 0) ? 1 : 5;
    endfunction

    function automatic lfsr_t lfsr_seed(input int idx);
        return lfsr_t'((64'd1 << lfsr_len(idx)) - 64'd1);
    endfunction

endpackage

// File: rtl/lfsr_stepper.sv
module lfsr_stepper #(
    parameter int LEN   = 7,
    parameter int TAP   = 6,
    parameter int WIDTH = 32
) (
    input  logic [LEN-1:0]   cur_i,
    output logic [LEN-1:0]   nxt_o,
    output logic [WIDTH-1:0] bits_o
);

    always_comb begin
        logic [LEN-1:0] s;
        logic           fb;
        s      = cur_i;
        bits_o = '0;
        for (int i = 0; i < WIDTH; i++) begin
            fb        = s[LEN-1] ^ s[TAP-1];
            bits_o[i] = fb;
            s         = {s[LEN-2:0], fb};
        end
        nxt_o = s;
    end

endmodule

// File: rtl/square_gen.sv
module square_gen #(
    parameter int WIDTH = 32,
    parameter int HALF  = 5,
    parameter int PW    = 4
) (
    input  logic [PW-1:0]    phase_i,
    output logic [WIDTH-1:0] bits_o,
    output logic [PW-1:0]    phase_o
);

    localparam int PERIOD = 2 * HALF;

    always_comb begin
        logic [PW-1:0] p;
        p      = phase_i;
        bits_o = '0;
        for (int i = 0; i < WIDTH; i++) begin
            bits_o[i] = (p < PW'(HALF));
            p         = (p == PW'(PERIOD - 1)) ? '0 : p + PW'(1);
        end
        phase_o = p;
    end

endmodule

// File: rtl/pattern_tx_gen.sv
module pattern_tx_gen
    import pattern_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [2:0]       pat_sel_i,
    input  logic             invert_i,
    output logic [WIDTH-1:0] data_o,
    output logic             valid_o
);

    if (WIDTH != 32 && WIDTH != 40) begin : gen_bad_width
        $error("pattern_tx_gen: WIDTH must be 32 or 40");
    end

    typedef struct packed {
        lfsr_t [NUM_LFSR-1:0]             lfsr;
        logic  [NUM_SQ-1:0][PHASE_W-1:0]  phase;
        logic  [2:0]                      sel;
        logic  [WIDTH-1:0]                data;
        logic                             valid;
    } state_t;

    state_t q, d;

    lfsr_t              base_l [NUM_LFSR];
    lfsr_t              nxt_l  [NUM_LFSR];
    logic [WIDTH-1:0]   lbits  [NUM_LFSR];
    logic [PHASE_W-1:0] base_p [NUM_SQ];
    logic [PHASE_W-1:0] nxt_p  [NUM_SQ];
    logic [WIDTH-1:0]   sbits  [NUM_SQ];
    logic [WIDTH-1:0]   word;
    logic               reload;

    // a new select code restarts every pattern from its seed
    assign reload = (pat_sel_i != q.sel);

    for (genvar g = 0; g < NUM_LFSR; g++) begin : gen_lfsr
        localparam int LEN = lfsr_len(g);
        localparam int TAP = lfsr_tap(g);
        logic [LEN-1:0] nxt_g;

        assign base_l[g] = reload ? lfsr_seed(g) : q.lfsr[g];

        lfsr_stepper #(
            .LEN   (LEN),
            .TAP   (TAP),
            .WIDTH (WIDTH)
        ) u_step (
            .cur_i  (base_l[g][LEN-1:0]),
            .nxt_o  (nxt_g),
            .bits_o (lbits[g])
        );

        assign nxt_l[g] = lfsr_t'(nxt_g);

        // R3
        lfsr_live_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            q.lfsr[g][LEN-1:0] != '0);
    end

    for (genvar k = 0; k < NUM_SQ; k++) begin : gen_sq
        localparam int HALF = sq_half(k);

        assign base_p[k] = reload ? '0 : q.phase[k];

        square_gen #(
            .WIDTH (WIDTH),
            .HALF  (HALF),
            .PW    (PHASE_W)
        ) u_sq (
            .phase_i (base_p[k]),
            .bits_o  (sbits[k]),
            .phase_o (nxt_p[k])
        );

        // R5
        phase_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            q.phase[k] < PHASE_W'(2 * HALF));
    end

    always_comb begin
        case (pat_sel_i)
            SEL_PRBS7:  word = lbits[0];
            SEL_PRBS15: word = lbits[1];
            SEL_PRBS23: word = lbits[2];
            SEL_PRBS31: word = lbits[3];
            SEL_CLK2:   word = sbits[0];
            SEL_CLK10:  word = sbits[1];
            default:    word = '0;
        endcase
    end

    always_comb begin
        d       = q;
        d.sel   = pat_sel_i;
        d.valid = en_i;
        for (int g = 0; g < NUM_LFSR; g++) begin
            d.lfsr[g] = base_l[g];
        end
        for (int k = 0; k < NUM_SQ; k++) begin
            d.phase[k] = base_p[k];
        end
        if (en_i) begin
            for (int g = 0; g < NUM_LFSR; g++) begin
                if (pat_sel_i == 3'(g)) begin
                    d.lfsr[g] = nxt_l[g];
                end
            end
            if (pat_sel_i == SEL_CLK2) begin
                d.phase[0] = nxt_p[0];
            end
            if (pat_sel_i == SEL_CLK10) begin
                d.phase[1] = nxt_p[1];
            end
            d.data = word ^ {WIDTH{invert_i}};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int g = 0; g < NUM_LFSR; g++) begin
                q.lfsr[g] <= lfsr_seed(g);
            end
            q.phase <= '0;
            q.sel   <= '0;
            q.data  <= '0;
            q.valid <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign data_o  = q.data;
    assign valid_o = q.valid;

    // R8
    valid_lag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> (valid_o == $past(en_i)));

    // R8
    hold_data_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(en_i)) |-> $stable(data_o));

endmodule

// File: tb/sim_pattern_tx_gen.sv
module sim_pattern_tx_gen;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         en;
    logic [2:0]   sel;
    logic         invert;
    logic [W-1:0] data_o;
    logic         valid_o;

    int errors = 0;
    int checks = 0;

    logic [30:0]  ms [4];
    int           lens [4] = '{7, 15, 23, 31};
    int           taps [4] = '{6, 14, 18, 28};
    int           m_pos;
    logic [2:0]   m_sel;
    logic [W-1:0] exp_data;
    logic         exp_valid;

    always #2 clk = ~clk;

    pattern_tx_gen #(.WIDTH(W)) u0 (
        .clk_i     (clk),
        .rst_i     (rst),
        .en_i      (en),
        .pat_sel_i (sel),
        .invert_i  (invert),
        .data_o    (data_o),
        .valid_o   (valid_o)
    );

    function automatic logic [30:0] ones(input int n);
        return 31'((64'd1 << n) - 64'd1);
    endfunction

    task automatic reseed();
        for (int j = 0; j < 4; j++) ms[j] = ones(lens[j]);
        m_pos = 0;
    endtask

    task automatic model_reset();
        reseed();
        m_sel     = 3'd0;
        exp_data  = '0;
        exp_valid = 1'b0;
    endtask

    task automatic model_step(input logic e, input logic [2:0] s, input logic inv);
        logic [W-1:0] w;
        logic         fb;
        if (s != m_sel) reseed();
        m_sel = s;
        if (e) begin
            w = '0;
            for (int i = 0; i < W; i++) begin
                if (s < 3'd4) begin
                    fb = ms[s[1:0]][lens[s[1:0]]-1] ^ ms[s[1:0]][taps[s[1:0]]-1];
                    w[i] = fb;
                    ms[s[1:0]] = ((ms[s[1:0]] << 1) | 31'(fb)) & ones(lens[s[1:0]]);
                end else if (s == 3'd4) begin
                    w[i] = (i % 2 == 0);
                end else if (s == 3'd5) begin
                    w[i] = (((m_pos + i) % 10) < 5);
                end
            end
            if (s == 3'd5) m_pos = (m_pos + W) % 10;
            exp_data  = w ^ {W{inv}};
            exp_valid = 1'b1;
        end else begin
            exp_valid = 1'b0;
        end
    endtask

    task automatic check(input string tag);
        checks++;
        if (data_o !== exp_data || valid_o !== exp_valid) begin
            errors++;
            $display("FAIL %s: data=%h valid=%b expected data=%h valid=%b",
                     tag, data_o, valid_o, exp_data, exp_valid);
        end
    endtask

    function automatic string tag_of(input logic [2:0] s, input logic inv);
        if (inv) return "R7";
        if (s == 3'd0) return "R2";
        if (s < 3'd4) return "R3";
        if (s == 3'd4) return "R4";
        if (s == 3'd5) return "R5";
        return "R6";
    endfunction

    task automatic cyc(input logic e, input logic [2:0] s, input logic inv, input string tag);
        en     = e;
        sel    = s;
        invert = inv;
        model_step(e, s, inv);
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1;
        en  = 1'b1;
        model_reset();
        repeat (2) @(negedge clk);
        check(tag);
        rst = 1'b0;
    endtask

    initial begin
        logic [W-1:0] first;
        rst = 1'b1; en = 1'b0; sel = 3'd0; invert = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        check("R1");
        rst = 1'b0;

        // every code, both polarities
        for (int s = 0; s < 8; s++)
            for (int v = 0; v < 2; v++)
                for (int n = 0; n < 40; n++)
                    cyc(1'b1, 3'(s), v[0], tag_of(3'(s), v[0]));

        // R8: enable gaps hold data and state
        for (int n = 0; n < 60; n++) cyc((n % 3) != 0, 3'd1, 1'b0, "R8");
        for (int n = 0; n < 30; n++) cyc((n % 4) == 1, 3'd5, 1'b0, "R8");

        // R9: select moved away and back while idle
        for (int n = 0; n < 7; n++) cyc(1'b1, 3'd5, 1'b0, "R5");
        cyc(1'b0, 3'd2, 1'b0, "R9");
        cyc(1'b0, 3'd5, 1'b0, "R9");
        for (int n = 0; n < 10; n++) cyc(1'b1, 3'd5, 1'b0, "R9");
        for (int n = 0; n < 5; n++) cyc(1'b1, 3'd3, 1'b0, "R3");
        cyc(1'b0, 3'd0, 1'b0, "R9");
        cyc(1'b0, 3'd3, 1'b0, "R9");
        for (int n = 0; n < 10; n++) cyc(1'b1, 3'd3, 1'b0, "R9");

        // R2: 127-word repeat of the shortest sequence
        cyc(1'b1, 3'd6, 1'b0, "R6");
        cyc(1'b1, 3'd0, 1'b0, "R2");
        first = data_o;
        for (int n = 0; n < 127; n++) cyc(1'b1, 3'd0, 1'b0, "R2");
        checks++;
        if (data_o !== first) begin
            errors++;
            $display("FAIL R2 period: data=%h expected=%h", data_o, first);
        end

        // R10: reset with unchanged select reseeds
        for (int n = 0; n < 7; n++) cyc(1'b1, 3'd0, 1'b0, "R2");
        do_reset("R10");
        for (int n = 0; n < 20; n++) cyc(1'b1, 3'd0, 1'b0, "R10");
        for (int n = 0; n < 3; n++) cyc(1'b1, 3'd5, 1'b1, "R7");
        do_reset("R1");
        for (int n = 0; n < 8; n++) cyc(1'b1, 3'd5, 1'b0, "R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R8 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule